// File: doc/BRIEF.md
# TLB Range Invalidation Sequencer

This block turns one request to drop the translations of a run of pages into an ordered stream of invalidate commands for a TLB command port. A request gives the first page number, a page count, an address-space identifier (ASID), a translation level hint and three mode flags. The flags are: range commands supported, 64KB start alignment required, and user copy wanted. The sequencer then presents one command at a time on a valid/ready port. Each command is a single-page invalidate, a scaled range invalidate, or a whole-ASID fallback, and each carries its 64-bit packed operand.

When range commands are allowed, the count is covered greedily. The sequencer begins at scale 3 and works down to scale 0. At each scale it issues the largest range command that fits, where the unit is 2^(5·scale+1) pages. Single-page commands are used instead when no range command fits: for a lone leftover page, for every page when range support is off, and as a prologue while the start is not 64KB aligned in alignment mode. A very large count collapses into one whole-ASID invalidate. The granule is fixed at 4KB, so a page number is the byte address shifted right by 12.

Top module: `tlbinv_seq`

## Requirements
- R1: A request whose page count is 0 emits no command, and `done` is high in the cycle after the request is accepted.
- R2: If the count is at least 2^21, or range support is off and the count is at least 512, exactly one command of kind 2 (whole ASID) is emitted. Its operand has the ASID in bits 63:48 and zeros in bits 47:0.
- R3: A page is sent as a command of kind 0 (single page) when range support is off, when exactly one page is left, or when alignment mode is on and page number bits 3:0 are not zero. Its operand has the ASID in bits 63:48, zeros in 47:44 and the page number in 43:0, and the page number then advances by one.
- R4: Otherwise a range attempt is made at the current scale s, which starts at 3 for each request and decreases by one (modulo 4) after every attempt. Let q = min(left, 32·2^(5s+1)) >> (5s+1). When q ≥ 1, a command of kind 1 (range) covering q·2^(5s+1) pages is emitted, and the page number and count advance by that span. When q = 0, no command is emitted for that attempt.
- R5: A range operand holds, from bit 63 down: ASID (63:48), granule code 1 (47:46), scale (45:44), q−1 (43:39), level hint (38:37) and base (36:0). The level field equals the level input only when that input is 1, 2 or 3; otherwise it is 0.
- R6: In alignment mode the range base is page number bits 40:4 (address bits 52:16). Otherwise it is page number bits 36:0.
- R7: With the user-copy flag set, each command is followed at once by a copy whose operand has bit 48 set in addition.
- R8: `req_ready` is high only while no sequence is in progress. A command with `cmd_valid` high and `cmd_ready` low keeps the same kind and operand in the next cycle.
- R9: `done` rises in the cycle after the last command of a sequence is accepted, and only then or as in R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request taken |
| req_pn | input | PN_W | First page number |
| req_count | input | CNT_W | Number of pages |
| req_asid | input | 16 | Address-space identifier |
| req_level | input | 3 | Level hint, values 1..3 meaningful |
| req_range_ok | input | 1 | Range commands may be used |
| req_align64k | input | 1 | Range starts must be 64KB aligned |
| req_user_dup | input | 1 | Emit each command twice, second with user flag |
| cmd_valid | output | 1 | Command present |
| cmd_ready | input | 1 | Command port accepts |
| cmd_kind | output | 2 | 0 single page, 1 range, 2 whole ASID |
| cmd_op | output | 64 | Packed operand |
| done | output | 1 | One-cycle pulse at sequence end |

## Verification
Acceptance of the final command and the completion pulse fall in adjacent cycles. With the user copy on, the final command is also the point where the duplicate branch and the finishing branch compete in one cycle. The sweep covers every count from 0 to 33 in each mode combination, with two start pages, while the command port withholds ready on an irregular pattern. The bench then judges that `done` follows exactly the negedge at which the last handshake was seen, and that the duplicate is never skipped or repeated. Large counts on both sides of the fallback thresholds round out the cases where the fallback and range decisions meet.

// File: rtl/tlbinv_pkg.sv
package tlbinv_pkg;

    localparam int OP_W       = 64;
    localparam int ASID_W     = 16;
    localparam int USER_BIT   = 48;
    localparam int BASE_W     = 37;
    localparam int NUM_W      = 5;
    localparam int SCALE_W    = 2;
    localparam int LVL_W      = 3;
    localparam int PAGE_FLD_W = 44;
    localparam int NUM_SCALES = 4;
    localparam logic [1:0] GRAN_4K = 2'd1;

    typedef enum logic [1:0] {
        K_PAGE  = 2'd0,
        K_RANGE = 2'd1,
        K_ASID  = 2'd2
    } cmd_kind_e;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_STEP = 2'd1,
        S_EMIT = 2'd2
    } seq_state_e;

    function automatic logic [OP_W-1:0] asid_word(input logic [ASID_W-1:0] id);
        return {id, {(OP_W-ASID_W){1'b0}}};
    endfunction

endpackage

// File: rtl/tlbinv_plan.sv
module tlbinv_plan
    import tlbinv_pkg::*;
#(
    parameter int CNT_W = 22
) (
    input  logic [3:0]         pn_low,
    input  logic [CNT_W-1:0]   left,
    input  logic [SCALE_W-1:0] scale,
    input  logic               rng_en,
    input  logic               aln_en,
    output logic               pick_single,
    output logic               range_hit,
    output logic [NUM_W-1:0]   num,
    output logic [CNT_W-1:0]   span
);

    logic [CNT_W-1:0] quo_s  [NUM_SCALES];
    logic [CNT_W-1:0] span_s [NUM_SCALES];

    for (genvar s = 0; s < NUM_SCALES; s++) begin : g_scale
        localparam int SH = 5 * s + 1;
        localparam logic [CNT_W-1:0] CAP = CNT_W'(32) << SH;
        logic [CNT_W-1:0] capped;
        assign capped    = (left > CAP) ? CAP : left;
        assign quo_s[s]  = capped >> SH;
        assign span_s[s] = quo_s[s] << SH;
    end

    always_comb begin
        pick_single = !rng_en || (left == CNT_W'(1)) || (aln_en && (pn_low != 4'd0));
        range_hit   = (quo_s[scale] != '0);
        num         = NUM_W'(quo_s[scale] - CNT_W'(1));
        span        = span_s[scale];
    end

endmodule

// File: rtl/tlbinv_opnd.sv
module tlbinv_opnd
    import tlbinv_pkg::*;
#(
    parameter int PN_W = 44
) (
    input  cmd_kind_e          kind,
    input  logic [PN_W-1:0]    pn,
    input  logic [ASID_W-1:0]  asid,
    input  logic [SCALE_W-1:0] scale,
    input  logic [NUM_W-1:0]   num,
    input  logic [LVL_W-1:0]   lvl,
    input  logic               aln_en,
    output logic [OP_W-1:0]    op
);

    logic [1:0]        lvl_fld;
    logic [BASE_W-1:0] base;

    always_comb begin
        lvl_fld = (lvl inside {3'd1, 3'd2, 3'd3}) ? lvl[1:0] : 2'd0;
        base    = aln_en ? pn[BASE_W+3:4] : pn[BASE_W-1:0];
        unique case (kind)
            K_PAGE:  op = {asid, 4'd0, pn[PAGE_FLD_W-1:0]};
            K_RANGE: op = {asid, GRAN_4K, scale, num, lvl_fld, base};
            default: op = asid_word(asid);
        endcase
    end

endmodule

// File: rtl/tlbinv_seq.sv
module tlbinv_seq
    import tlbinv_pkg::*;
#(
    parameter int PN_W         = 44,
    parameter int CNT_W        = 22,
    parameter int SINGLE_LIMIT = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [PN_W-1:0]   req_pn,
    input  logic [CNT_W-1:0]  req_count,
    input  logic [15:0]       req_asid,
    input  logic [2:0]        req_level,
    input  logic              req_range_ok,
    input  logic              req_align64k,
    input  logic              req_user_dup,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [1:0]        cmd_kind,
    output logic [63:0]       cmd_op,
    output logic              done
);

    localparam logic [CNT_W-1:0] RANGE_LIMIT = CNT_W'(32) << 16;
    localparam logic [CNT_W-1:0] FLAT_LIMIT  = CNT_W'(SINGLE_LIMIT);
    localparam logic [OP_W-1:0]  USER_MASK   = OP_W'(1) << USER_BIT;

    typedef struct packed {
        seq_state_e         st;
        logic [PN_W-1:0]    pn;
        logic [CNT_W-1:0]   left;
        logic [SCALE_W-1:0] scale;
        logic [ASID_W-1:0]  asid;
        logic [LVL_W-1:0]   lvl;
        logic               rng;
        logic               aln;
        logic               dup;
        logic               last;
        logic               second;
        cmd_kind_e          kind;
        logic [OP_W-1:0]    op;
        logic               done;
    } seq_t;

    seq_t q, d;

    logic               pick_single;
    logic               range_hit;
    logic [NUM_W-1:0]   num;
    logic [CNT_W-1:0]   span;
    cmd_kind_e          step_kind;
    logic [OP_W-1:0]    step_op;

    tlbinv_plan #(.CNT_W(CNT_W)) u_plan (
        .pn_low      (q.pn[3:0]),
        .left        (q.left),
        .scale       (q.scale),
        .rng_en      (q.rng),
        .aln_en      (q.aln),
        .pick_single (pick_single),
        .range_hit   (range_hit),
        .num         (num),
        .span        (span)
    );

    always_comb step_kind = pick_single ? K_PAGE : K_RANGE;

    tlbinv_opnd #(.PN_W(PN_W)) u_opnd (
        .kind   (step_kind),
        .pn     (q.pn),
        .asid   (q.asid),
        .scale  (q.scale),
        .num    (num),
        .lvl    (q.lvl),
        .aln_en (q.aln),
        .op     (step_op)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        unique case (q.st)
            S_IDLE: begin
                if (req_valid) begin
                    d.pn     = req_pn;
                    d.left   = req_count;
                    d.asid   = req_asid;
                    d.lvl    = req_level;
                    d.rng    = req_range_ok;
                    d.aln    = req_align64k;
                    d.dup    = req_user_dup;
                    d.scale  = SCALE_W'(NUM_SCALES - 1);
                    d.second = 1'b0;
                    d.last   = 1'b0;
                    if (req_count == '0) begin
                        d.done = 1'b1;
                    end else if ((req_count >= RANGE_LIMIT) ||
                                 (!req_range_ok && (req_count >= FLAT_LIMIT))) begin
                        d.kind = K_ASID;
                        d.op   = asid_word(req_asid);
                        d.last = 1'b1;
                        d.st   = S_EMIT;
                    end else begin
                        d.st = S_STEP;
                    end
                end
            end
            S_STEP: begin
                if (q.left == '0) begin
                    d.st   = S_IDLE;
                    d.done = 1'b1;
                end else if (pick_single) begin
                    d.kind = K_PAGE;
                    d.op   = step_op;
                    d.pn   = q.pn + PN_W'(1);
                    d.left = q.left - CNT_W'(1);
                    d.last = (q.left == CNT_W'(1));
                    d.st   = S_EMIT;
                end else begin
                    d.scale = q.scale - SCALE_W'(1);
                    if (range_hit) begin
                        d.kind = K_RANGE;
                        d.op   = step_op;
                        d.pn   = q.pn + PN_W'(span);
                        d.left = q.left - span;
                        d.last = (q.left == span);
                        d.st   = S_EMIT;
                    end
                end
            end
            S_EMIT: begin
                if (cmd_ready) begin
                    if (q.dup && !q.second) begin
                        d.second = 1'b1;
                        d.op     = q.op | USER_MASK;
                    end else begin
                        d.second = 1'b0;
                        if (q.last) begin
                            d.st   = S_IDLE;
                            d.done = 1'b1;
                        end else begin
                            d.st = S_STEP;
                        end
                    end
                end
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        req_ready = (q.st == S_IDLE);
        cmd_valid = (q.st == S_EMIT);
        cmd_kind  = q.kind;
        cmd_op    = q.op;
        done      = q.done;
    end

endmodule

// File: rtl/tlbinv_seq_chk.sv
module tlbinv_seq_chk #(
    parameter int CNT_W = 22
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic [CNT_W-1:0] req_count,
    input logic             cmd_valid,
    input logic             cmd_ready,
    input logic [1:0]       cmd_kind,
    input logic [63:0]      cmd_op,
    input logic             done
);

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_op) && $stable(cmd_kind))) // R8
        else $error("command changed while stalled");

    AST_NO_REQ_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> !req_ready) // R8
        else $error("request port open during a sequence");

    AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(cmd_valid && cmd_ready) || $past(req_valid && req_ready && (req_count == '0)))) // R9
        else $error("done without a finishing event");

    AST_ASID_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_kind == 2'd2) |-> (cmd_op[47:0] == 48'd0)) // R2
        else $error("whole-ASID operand has low bits set");

    AST_PAGE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_kind == 2'd0) |-> (cmd_op[47:44] == 4'd0)) // R3
        else $error("single-page operand has bits 47:44 set");

    AST_KIND_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_kind != 2'd3)) // R4
        else $error("illegal command kind");

endmodule

bind tlbinv_seq tlbinv_seq_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/tb_tlbinv_seq.sv
module tb_tlbinv_seq;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic        req_ready;
    logic [43:0] req_pn;
    logic [21:0] req_count;
    logic [15:0] req_asid;
    logic [2:0]  req_level;
    logic        req_range_ok;
    logic        req_align64k;
    logic        req_user_dup;
    logic        cmd_valid;
    logic        cmd_ready;
    logic [1:0]  cmd_kind;
    logic [63:0] cmd_op;
    logic        done;

    always #10 clk = ~clk;

    tlbinv_seq dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_pn(req_pn), .req_count(req_count), .req_asid(req_asid),
        .req_level(req_level), .req_range_ok(req_range_ok),
        .req_align64k(req_align64k), .req_user_dup(req_user_dup),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_kind(cmd_kind), .cmd_op(cmd_op), .done(done)
    );

    int n_run  = 0;
    int n_fail = 0;
    int cyc    = 0;
    always @(posedge clk) cyc++;

    logic [1:0]  ek [0:2047];
    logic [63:0] eo [0:2047];
    int ne;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic push(input logic [1:0] k, input logic [63:0] op, input bit dup);
        ek[ne] = k; eo[ne] = op; ne++;
        if (dup) begin
            ek[ne] = k; eo[ne] = op | (64'd1 << 48); ne++;
        end
    endtask

    task automatic model(input longint pn0, input longint cnt, input logic [15:0] asid,
                         input logic [2:0] lvl, input bit rng, input bit aln, input bit dup);
        longint pn, left, q, cap;
        int sc, sh;
        logic [1:0]  lv;
        logic [36:0] base;
        ne = 0;
        if (cnt == 0) return;
        if (cnt >= (longint'(1) << 21) || (!rng && cnt >= 512)) begin
            push(2'd2, {asid, 48'd0}, dup);
            return;
        end
        pn = pn0; left = cnt; sc = 3;
        while (left > 0) begin
            if (!rng || left == 1 || (aln && pn[3:0] != 4'd0)) begin
                push(2'd0, {asid, 4'd0, pn[43:0]}, dup);
                pn++; left--;
            end else begin
                sh  = 5 * sc + 1;
                cap = longint'(32) << sh;
                q   = ((left > cap) ? cap : left) >> sh;
                if (q >= 1) begin
                    lv   = (lvl >= 3'd1 && lvl <= 3'd3) ? lvl[1:0] : 2'd0;
                    base = aln ? pn[40:4] : pn[36:0];
                    push(2'd1, {asid, 2'd1, sc[1:0], 5'(q - 1), lv, base}, dup);
                    pn   += q << sh;
                    left -= q << sh;
                end
                sc = (sc + 3) % 4;
            end
        end
    endtask

    task automatic run(input longint pn0, input longint cnt, input logic [15:0] asid,
                       input logic [2:0] lvl, input bit rng, input bit aln, input bit dup,
                       input int seed, input string tag);
        int  got = 0;
        int  guard = 0;
        bit  seen = 0;
        bit  hs_prev = 1;
        bit  have_prev = 0;
        bit  unstable = 0;
        bit  busy_bad = 0;
        logic [1:0]  pk = '0;
        logic [63:0] pop = '0;
        model(pn0, cnt, asid, lvl, rng, aln, dup);
        @(negedge clk);
        req_pn = pn0[43:0]; req_count = cnt[21:0]; req_asid = asid; req_level = lvl;
        req_range_ok = rng; req_align64k = aln; req_user_dup = dup;
        req_valid = 1'b1; cmd_ready = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        while (!seen) begin
            if (done) begin
                seen = 1;
                chk(hs_prev, {tag, " R9 done timing"}, 64'(done), 64'd1);
            end else begin
                if (req_ready) busy_bad = 1;
                if (have_prev && !(cmd_valid && cmd_kind == pk && cmd_op == pop)) unstable = 1;
                cmd_ready = ((seed + guard * 5 + guard / 3) % 3) != 0;
                hs_prev   = cmd_valid && cmd_ready;
                have_prev = cmd_valid && !cmd_ready;
                pk = cmd_kind; pop = cmd_op;
                if (hs_prev) begin
                    if (got < ne)
                        chk(cmd_kind == ek[got] && cmd_op == eo[got],
                            $sformatf("%s cmd %0d kind %0d/%0d", tag, got, cmd_kind, ek[got]),
                            cmd_op, eo[got]);
                    else
                        chk(1'b0, {tag, " extra command"}, cmd_op, 64'd0);
                    got++;
                end
                guard++;
                if (guard > 6000) begin
                    chk(1'b0, {tag, " R9 no done"}, 64'(got), 64'(ne));
                    seen = 1;
                end
                @(negedge clk);
            end
        end
        cmd_ready = 1'b0;
        chk(got == ne, {tag, " command count"}, 64'(got), 64'(ne));
        chk(!unstable, {tag, " R8 stalled command held"}, 64'(unstable), 64'd0);
        chk(!busy_bad, {tag, " R8 req_ready low while busy"}, 64'(busy_bad), 64'd0);
    endtask

    initial begin
        wait (cyc > 190000);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=<190000", cyc);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; cmd_ready = 1'b0;
        req_pn = '0; req_count = '0; req_asid = '0; req_level = '0;
        req_range_ok = 1'b0; req_align64k = 1'b0; req_user_dup = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !cmd_valid && !done, "reset state R8 R9",
            {61'd0, req_ready, cmd_valid, done}, 64'd4);

        for (int r = 0; r < 2; r++)
            for (int a = 0; a < 2; a++)
                for (int u = 0; u < 2; u++)
                    for (int c = 0; c < 34; c++)
                        for (int s = 0; s < 2; s++) begin
                            string tag;
                            tag = $sformatf("%s%s%s%s n=%0d",
                                (c == 0) ? "R1 " : "",
                                (r != 0) ? "R4 R5 " : "R3 ",
                                (a != 0) ? "R6 " : "",
                                (u != 0) ? "R7" : "", c);
                            run((s != 0) ? 13 : 0, c, 16'(16'h1200 + c * 37 + s),
                                3'(c % 8), r[0], a[0], u[0], c + s + u, tag);
                        end

        run(0, 511, 16'hbeef, 3'd2, 1'b0, 1'b0, 1'b0, 1, "R3 flat limit-1");
        run(3, 512, 16'hbeef, 3'd2, 1'b0, 1'b0, 1'b1, 2, "R2 R7 flat limit");
        run(0, 64'd2097152, 16'h0a0a, 3'd1, 1'b1, 1'b0, 1'b0, 0, "R2 range limit");
        run(0, 64'd2097151, 16'h0b0b, 3'd3, 1'b1, 1'b0, 1'b1, 1, "R4 R5 R7 just below limit");
        run(7, 3000, 16'h4321, 3'd5, 1'b1, 1'b1, 1'b0, 2, "R6 R3 aligned prologue");
        run(5, 70000, 16'h7777, 3'd1, 1'b1, 1'b0, 1'b0, 0, "R4 R5 large");
        run(64'h0ffffff0, 40000, 16'h0001, 3'd2, 1'b1, 1'b1, 1'b1, 1, "R6 R7 high address");

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule